// File: doc/BRIEF.md
# IR run-length carrier transmitter

This block turns a stream of run-length symbols into a drive signal for an infrared emitter LED. Software pushes bytes into a 16-entry transmit queue. Each byte names a pulse or a space and gives its length in time units of 10 us. A small sequencer takes one symbol at a time. While a pulse symbol plays, the selected LED output carries a carrier square wave. While a space symbol plays, the output is held at its idle level. The carrier period and its high time are both counted in reference-clock cycles, and software programs them for anything from 30 to 60 kHz. At 100 MHz, 36 kHz with a 7 us high time is a period of 2778 and a high time of 700.

Transmission has a defined end. Just before it writes the final byte, software strobes an end-of-transmission marker. When the queue runs dry with the marker set, the sequencer returns quietly to idle. When it runs dry without the marker, the block enters a stall state and reports an underrun until software clears it. Three events are visible through a masked interrupt identification vector: queue running low, error, and transmitter empty. An optional receive-block output lets a neighbouring receiver ignore its input while a burst is playing.

The sequencer has three states. `ST_IDLE` waits for data. `ST_SEND` plays a symbol. `ST_STALL` holds after an underrun. The transitions are:
- IDLE to SEND: the queue is not empty.
- SEND to SEND: a symbol ends and the queue holds another byte.
- SEND to IDLE: a symbol ends, the queue is empty and the marker is armed.
- SEND to STALL: a symbol ends, the queue is empty and the marker is not armed.
- STALL to IDLE: the underrun is cleared.

Top module: `ir_rl_tx`

## Requirements
- R1: Bit 7 of a queued byte selects the symbol kind: 0 means pulse and 1 means space. Bits 6:0 hold a value v, and the symbol lasts (v+1)×UNIT_CYCLES clock cycles in `ST_SEND`.
- R2: When a symbol ends and the queue holds another byte, the next symbol starts on the following cycle with no idle gap.
- R3: During a pulse symbol, the active output is high for `car_high` cycles at the start of every `car_period`-cycle carrier period. The carrier phase restarts at the first cycle of every symbol. The LED outputs follow the carrier with one register cycle of latency.
- R4: The LED outputs sit at their idle level during space symbols, in `ST_IDLE` and in `ST_STALL`.
- R5: The queue holds 16 bytes. A write while the queue is full is dropped.
- R6: A pulse on `eot_set` arms the end marker. A symbol that ends with an empty queue and the marker armed returns the sequencer to `ST_IDLE` and disarms the marker.
- R7: A symbol that ends with an empty queue and the marker not armed enters `ST_STALL`. The stall holds until a pulse on `under_clr`. Bytes written during the stall are kept and sent afterwards.
- R8: The status vector has these bits: bit 1 is tx-low (in `ST_SEND` with 3 or fewer bytes queued), bit 2 is error (in `ST_STALL`), and bit 5 is empty (in `ST_IDLE` with an empty queue). The other bits read 0. `irq_id` equals the status ANDed with `irq_en`, and `irq` is the OR of `irq_id`.
- R9: `led_sel` picks exactly one of the four outputs to carry the carrier, and the other three stay idle. `led_inv` flips the polarity of all four, so the idle level equals `led_inv`.
- R10: `rx_block` is high exactly when `rx_mask_en` is high and the sequencer is in `ST_SEND`.
- R11: After reset, all LED outputs sit at their idle level, the sequencer is in `ST_IDLE` with an empty queue, and the marker is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Run-length byte to queue |
| eot_set | input | 1 | Arms the end-of-transmission marker |
| under_clr | input | 1 | Clears the underrun stall |
| car_period | input | 16 | Carrier period in clock cycles |
| car_high | input | 16 | Carrier high time in clock cycles |
| led_sel | input | 2 | Selects the active LED output |
| led_inv | input | 1 | Inverts all LED outputs |
| irq_en | input | 8 | Interrupt enable mask |
| rx_mask_en | input | 1 | Enables receive blocking during sends |
| led | output | 4 | LED drive outputs |
| irq | output | 1 | Interrupt request |
| irq_id | output | 8 | Masked interrupt identification |
| rx_block | output | 1 | Receive-ignore request to a neighbour |

## Verification
Every cycle, the assertions watch the following:
- the queue never goes past its depth and never pops while empty;
- entry into the stall always follows a disarmed marker;
- back-to-back symbols reload without a gap;
- each new pulse opens with a high carrier phase;
- no more than one LED output is ever active;
- the registered carrier stays low outside pulse symbols.

The exact symbol lengths, the carrier phase inside long bursts, dropped writes on a full queue, and bytes held and replayed across a stall can only be shown by the bench scenarios. In those scenarios, a behavioural model of the queue and the symbol timing is compared against every output on every clock.

// File: rtl/ir_rl_tx_pkg.sv
package ir_rl_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_STALL = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic       is_space;
        logic [6:0] units;
    } rl_sym_t;

    localparam int STAT_LOW   = 1;
    localparam int STAT_ERR   = 2;
    localparam int STAT_EMPTY = 5;

endpackage

// File: rtl/ir_rl_fifo.sv
module ir_rl_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            unique case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5: occupancy bounded by the depth
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: the sequencer never takes a byte from an empty queue
    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/ir_rl_carrier.sv
module ir_rl_carrier #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          restart,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] high,
    output logic          mod
);

    logic [CW-1:0] phase;
    logic [CW:0]   phase_inc;

    assign phase_inc = {1'b0, phase} + 1'b1;
    assign mod       = active && (phase < high);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !active) begin
            phase <= '0;
        end else if (phase_inc >= {1'b0, period}) begin
            phase <= '0;
        end else begin
            phase <= phase_inc[CW-1:0];
        end
    end

    // R3: every burst opens with the high part of a carrier period
    a_r3_burst_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!active || high == '0 || mod));

endmodule

// File: rtl/ir_rl_seq.sv
module ir_rl_seq
    import ir_rl_tx_pkg::*;
#(
    parameter int UNIT_CYCLES = 1000,
    localparam int TICK_W     = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      empty,
    input  rl_sym_t   head,
    input  logic      eot_set,
    input  logic      under_clr,
    output logic      pop,
    output tx_state_e state,
    output logic      sym_space
);

    tx_state_e         nxt;
    logic [6:0]        units_q;
    logic [TICK_W-1:0] tick_q;
    logic              eot_q;
    logic              at_end;
    logic              clean_end;

    assign at_end    = (tick_q == TICK_W'(UNIT_CYCLES - 1)) && (units_q == '0);
    assign clean_end = (state == ST_SEND) && at_end && empty && eot_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!empty) nxt = ST_SEND;
            end
            ST_SEND: begin
                if (at_end && empty) nxt = eot_q ? ST_IDLE : ST_STALL;
            end
            ST_STALL: begin
                if (under_clr) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        pop = 1'b0;
        unique case (state)
            ST_IDLE:  pop = !empty;
            ST_SEND:  pop = at_end && !empty;
            ST_STALL: pop = 1'b0;
            default:  pop = 1'b0;
        endcase
    end

    // symbol timers and end marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_space <= 1'b0;
            units_q   <= '0;
            tick_q    <= '0;
            eot_q     <= 1'b0;
        end else begin
            if (pop) begin
                sym_space <= head.is_space;
                units_q   <= head.units;
                tick_q    <= '0;
            end else if (state == ST_SEND) begin
                if (tick_q == TICK_W'(UNIT_CYCLES - 1)) begin
                    tick_q <= '0;
                    if (units_q != '0) units_q <= units_q - 1'b1;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
            if (eot_set) begin
                eot_q <= 1'b1;
            end else if (clean_end) begin
                eot_q <= 1'b0;
            end
        end
    end

    // R7: a stall is entered only when the marker was not armed
    a_r7_stall_needs_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_STALL) |-> !$past(eot_q));

    // R6: a clean end returns to idle with the marker disarmed
    a_r6_clean_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_end && !eot_set) |=> (state == ST_IDLE && !eot_q));

    // R2: a queued byte reloads the timers with no gap
    a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && at_end && !empty) |=> (state == ST_SEND && tick_q == '0));

endmodule

// File: rtl/ir_rl_tx.sv
module ir_rl_tx
    import ir_rl_tx_pkg::*;
#(
    parameter int UNIT_CYCLES = 1000,
    parameter int DEPTH       = 16,
    parameter int LOW_MARK    = 3,
    parameter int NUM_LED     = 4,
    parameter int CAR_W       = 16,
    localparam int SEL_W      = (NUM_LED > 1) ? $clog2(NUM_LED) : 1,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               eot_set,
    input  logic               under_clr,
    input  logic [CAR_W-1:0]   car_period,
    input  logic [CAR_W-1:0]   car_high,
    input  logic [SEL_W-1:0]   led_sel,
    input  logic               led_inv,
    input  logic [7:0]         irq_en,
    input  logic               rx_mask_en,
    output logic [NUM_LED-1:0] led,
    output logic               irq,
    output logic [7:0]         irq_id,
    output logic               rx_block
);

    logic             pop;
    logic [7:0]       head;
    logic [LVL_W-1:0] level;
    logic             q_empty;
    logic             q_full;
    tx_state_e        state;
    logic             sym_space;
    logic             car_active;
    logic             mod;
    logic             mod_q;
    logic [7:0]       status;

    ir_rl_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (pop),
        .dout  (head),
        .count (level),
        .empty (q_empty),
        .full  (q_full)
    );

    ir_rl_seq #(.UNIT_CYCLES(UNIT_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .empty     (q_empty),
        .head      (rl_sym_t'(head)),
        .eot_set   (eot_set),
        .under_clr (under_clr),
        .pop       (pop),
        .state     (state),
        .sym_space (sym_space)
    );

    assign car_active = (state == ST_SEND) && !sym_space;

    ir_rl_carrier #(.CW(CAR_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (car_active),
        .restart (pop),
        .period  (car_period),
        .high    (car_high),
        .mod     (mod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= 1'b0;
        end else begin
            mod_q <= mod;
        end
    end

    for (genvar g = 0; g < NUM_LED; g++) begin : g_led
        assign led[g] = ((int'(led_sel) == g) ? mod_q : 1'b0) ^ led_inv;
    end

    always_comb begin
        status             = '0;
        status[STAT_LOW]   = (state == ST_SEND) && (int'(level) <= LOW_MARK);
        status[STAT_ERR]   = (state == ST_STALL);
        status[STAT_EMPTY] = (state == ST_IDLE) && q_empty;
    end

    assign irq_id   = status & irq_en;
    assign irq      = |irq_id;
    assign rx_block = rx_mask_en && (state == ST_SEND);

    // R9: at most one output ever differs from the idle level
    a_r9_single_led: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(led ^ {NUM_LED{led_inv}}) <= 1);

    // R4: no carrier is registered after a space, idle or stall cycle
    a_r4_quiet_outside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SEND || sym_space) |=> !mod_q);

endmodule

// File: tb/ir_rl_tx_test.sv
module ir_rl_tx_test;
    localparam int UNIT  = 3;
    localparam int DEPTH = 16;
    localparam int LOWM  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        eot_set = 1'b0;
    logic        under_clr = 1'b0;
    logic [15:0] car_period = 16'd5;
    logic [15:0] car_high = 16'd2;
    logic [1:0]  led_sel = '0;
    logic        led_inv = 1'b0;
    logic [7:0]  irq_en = 8'hFF;
    logic        rx_mask_en = 1'b0;
    logic [3:0]  led;
    logic        irq;
    logic [7:0]  irq_id;
    logic        rx_block;

    always #5 clk = ~clk;

    ir_rl_tx #(.UNIT_CYCLES(UNIT), .DEPTH(DEPTH), .LOW_MARK(LOWM)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .eot_set(eot_set), .under_clr(under_clr), .car_period(car_period),
        .car_high(car_high), .led_sel(led_sel), .led_inv(led_inv),
        .irq_en(irq_en), .rx_mask_en(rx_mask_en), .led(led), .irq(irq),
        .irq_id(irq_id), .rx_block(rx_block)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 0;
    string req = "R11";

    // behavioural reference: queue plus total-cycle symbol timing
    logic [7:0] mq[$];
    int  m_st = 0;   // 0 idle, 1 sending, 2 stalled
    bit  m_space = 0;
    int  m_len = 0;
    int  m_pos = 0;
    bit  m_eot = 0;
    bit  m_modq = 0;

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int  st0;
        bit  cur_mod;
        bit  full;
        bit  do_pop;
        bit  nxt_eot;
        logic [7:0] b;
        if (!rst_n) begin
            mq.delete();
            m_st = 0; m_space = 0; m_len = 0; m_pos = 0; m_eot = 0; m_modq = 0;
        end else begin
            st0     = m_st;
            cur_mod = (m_st == 1) && !m_space && ((m_pos % int'(car_period)) < int'(car_high));
            full    = (mq.size() >= DEPTH);
            do_pop  = 0;
            nxt_eot = m_eot;
            if (st0 == 0 && mq.size() > 0) do_pop = 1;
            if (st0 == 1) begin
                if (m_pos == m_len - 1) begin
                    if (mq.size() > 0) do_pop = 1;
                    else if (m_eot) begin m_st = 0; nxt_eot = 0; end
                    else m_st = 2;
                end else begin
                    m_pos++;
                end
            end
            if (st0 == 2 && under_clr) m_st = 0;
            if (do_pop) begin
                b = mq.pop_front();
                m_st = 1; m_space = b[7]; m_len = (int'(b[6:0]) + 1) * UNIT; m_pos = 0;
            end
            if (eot_set) nxt_eot = 1;
            m_eot = nxt_eot;
            if (wr_en && !full) mq.push_back(wr_data);
            m_modq = cur_mod;
        end
    end

    always @(negedge clk) begin
        logic [3:0] e_led;
        logic [7:0] e_stat;
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) e_led[i] = ((int'(led_sel) == i) ? m_modq : 1'b0) ^ led_inv;
            e_stat = '0;
            e_stat[1] = (m_st == 1) && (mq.size() <= LOWM);
            e_stat[2] = (m_st == 2);
            e_stat[5] = (m_st == 0) && (mq.size() == 0);
            chk("led", int'(led), int'(e_led));
            chk("irq_id", int'(irq_id), int'(e_stat & irq_en));
            chk("irq", int'(irq), int'(|(e_stat & irq_en)));
            chk("rx_block", int'(rx_block), int'(rx_mask_en && m_st == 1));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(logic [7:0] v);
        wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0;
    endtask

    task automatic mark_end();
        eot_set = 1'b1; tick(); eot_set = 1'b0;
    endtask

    task automatic wait_state(int st);
        for (int n = 0; n < 5000; n++) begin
            if (m_st == st && (st == 2 || mq.size() == 0)) break;
            tick();
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #3;
        // R11: reset state at the ports
        chk("reset led", int'(led), 0);
        chk("reset irq_id", int'(irq_id), 'h20);
        chk("reset rx_block", int'(rx_block), 0);
        tick();

        // R1: pulse, space, pulse with end marker
        req = "R1";
        push(8'h02); push(8'h81); mark_end(); push(8'h01);
        wait_state(0); repeat (4) tick();

        // R3: longer pulses, other carrier shape
        req = "R3"; car_period = 16'd7; car_high = 16'd3;
        push(8'h05); push(8'h04); mark_end(); push(8'h80);
        wait_state(0); repeat (4) tick();

        // R2: single-unit symbols back to back
        req = "R2"; car_period = 16'd2; car_high = 16'd1;
        push(8'h00); push(8'h80); push(8'h00); mark_end(); push(8'h80);
        wait_state(0); repeat (4) tick();

        // R9: other output, inverted polarity
        req = "R9"; led_sel = 2'd3; led_inv = 1'b1; car_period = 16'd4; car_high = 16'd1;
        push(8'h03); push(8'h81); mark_end(); push(8'h02);
        wait_state(0); repeat (4) tick();
        led_sel = 2'd1; led_inv = 1'b0;

        // R7: missing end marker stalls
        req = "R7";
        push(8'h01);
        wait_state(2);
        // R4: output idle while stalled
        req = "R4";
        repeat (5) tick();
        chk("stall err bit", int'(irq_id[2]), 1);
        chk("stall led idle", int'(led), 0);

        // R5: overfill during the stall, then release
        req = "R5";
        for (int i = 0; i < 18; i++) push(8'((i % 4) | ((i % 2) << 7)));
        under_clr = 1'b1; tick(); under_clr = 1'b0;
        mark_end();
        wait_state(0); repeat (4) tick();

        // R6: clean end reports empty, no error
        req = "R6";
        chk("empty after end", int'(irq_id), 'h20);

        // R8: masked identification
        req = "R8"; irq_en = 8'h06;
        push(8'h03); push(8'h03); mark_end(); push(8'h03);
        wait_state(0); repeat (3) tick();
        irq_en = 8'h00;
        push(8'h02); mark_end(); push(8'h02);
        wait_state(0); repeat (3) tick();
        irq_en = 8'hFF;

        // R10: receive block while sending
        req = "R10"; rx_mask_en = 1'b1;
        push(8'h02); mark_end(); push(8'h82);
        wait_state(0); repeat (4) tick();
        rx_mask_en = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule